// File: doc/BRIEF.md
# Adder-Subtractor with Selectable Overflow Flag

This block is a purely combinational arithmetic unit. It takes two operands of a parameterised width and returns either their sum or their difference. A single control bit picks the operation. Subtraction reuses the same ripple-carry adder. It inverts every bit of the second operand and feeds a carry-in of one, which adds the two's complement of that operand.

A second control bit states how the operands should be read, as two's complement or as unsigned. One error output reports whether the true result fits in the output width under that reading. In signed mode the flag is formed from the sign bits of the two adder inputs and of the sum. In unsigned mode it is formed from the adder's carry-out together with the operation bit. A two-way select picks which of the two flags reaches the error output. The block holds no state, so its outputs follow its inputs within the same cycle.

Top module: `addsub_ovf`

## Requirements
- R1: With `sub_sel` = 0 (add), `result` equals (`op_x` + `op_y`) modulo 2^WIDTH.
- R2: With `sub_sel` = 1 (subtract), `result` equals (`op_x` - `op_y`) modulo 2^WIDTH.
- R3: With `signed_mode` = 1 and `sub_sel` = 0, and both operands read as two's complement, `err` is 1 exactly when the true sum lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: With `signed_mode` = 1 and `sub_sel` = 1, `err` is 1 exactly when the true signed difference `op_x` - `op_y` lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R5: With `signed_mode` = 0 and `sub_sel` = 0, `err` is 1 exactly when the unsigned sum is 2^WIDTH or more, which is the adder's carry-out.
- R6: With `signed_mode` = 0 and `sub_sel` = 1, `err` is 1 exactly when `op_y` > `op_x` as unsigned values, meaning a borrow occurs.
- R7: `result` does not depend on `signed_mode`. For fixed operands and operation, both modes give the same `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | WIDTH | First operand (minuend when subtracting) |
| op_y | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| signed_mode | input | 1 | 1 = operands are two's complement, 0 = unsigned |
| result | output | WIDTH | Sum or difference, wrapped to WIDTH bits |
| err | output | 1 | Out-of-range flag judged under `signed_mode` |

## Verification
The bench builds two copies of the block, one at the default WIDTH of 4 and one at WIDTH 6. At 4 bits every operand pair fits in 1024 vectors across both operations and both modes. At 6 bits the sweep still stays exhaustive at 16384 vectors. The second copy checks that the sign-bit position and the carry-out follow the width parameter rather than a fixed bit 3. Both sweeps reach every corner by enumeration: the most negative value minus one, zero minus the largest unsigned value, and all-ones plus one.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    ADDSUB_ADD = 1'b0,
    ADDSUB_SUB = 1'b1
  } addsub_op_e;

  // one-bit full adder pieces
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a ^ b));
  endfunction

  // signed range violation: like-signed adder inputs, sum of opposite sign
  function automatic logic ovf_signed(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // unsigned range violation: carry on add, missing carry on subtract
  function automatic logic ovf_unsigned(input logic cout, input logic sub);
    return cout ^ sub;
  endfunction

endpackage

// File: rtl/addsub_operand.sv
module addsub_operand
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] y_in,
  input  logic         sub_sel,
  output logic [W-1:0] b_out,
  output logic         carry_in
);
  addsub_op_e op;
  assign op       = addsub_op_e'(sub_sel);
  assign b_out    = y_in ^ {W{op == ADDSUB_SUB}};
  assign carry_in = (op == ADDSUB_SUB);
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = fa_sum(a[i], b[i], chain[i]);
    assign chain[i+1] = fa_carry(a[i], b[i], chain[i]);
  end

  assign cout = chain[W];
endmodule

// File: rtl/addsub_flag.sv
module addsub_flag
  import addsub_pkg::*;
(
  input  logic a_msb,
  input  logic b_msb,
  input  logic s_msb,
  input  logic cout,
  input  logic sub_sel,
  input  logic signed_mode,
  output logic sgn_err,
  output logic uns_err,
  output logic err
);
  assign sgn_err = ovf_signed(a_msb, b_msb, s_msb);
  assign uns_err = ovf_unsigned(cout, sub_sel);
  // mode bit steers the two-way select: 1 picks the signed rule
  assign err     = signed_mode ? sgn_err : uns_err;
endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  input  logic             sub_sel,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] result,
  output logic             err
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum_w;
  logic             carry_out;
  logic             sgn_err;
  logic             uns_err;

  addsub_operand #(.W(WIDTH)) u_operand (
    .y_in     (op_y),
    .sub_sel  (sub_sel),
    .b_out    (b_eff),
    .carry_in (cin)
  );

  addsub_ripple #(.W(WIDTH)) u_ripple (
    .a    (op_x),
    .b    (b_eff),
    .cin  (cin),
    .sum  (sum_w),
    .cout (carry_out)
  );

  addsub_flag u_flag (
    .a_msb       (op_x[MSB]),
    .b_msb       (b_eff[MSB]),
    .s_msb       (sum_w[MSB]),
    .cout        (carry_out),
    .sub_sel     (sub_sel),
    .signed_mode (signed_mode),
    .sgn_err     (sgn_err),
    .uns_err     (uns_err),
    .err         (err)
  );

  assign result = sum_w;
endmodule

// File: rtl/addsub_ovf_chk.sv
module addsub_ovf_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] op_x,
  input logic [W-1:0] op_y,
  input logic         sub_sel,
  input logic         signed_mode,
  input logic [W-1:0] result,
  input logic         err,
  input logic         carry_out
);
  logic [W:0]        u_sum;
  logic [W:0]        u_dif;
  logic signed [W:0] s_sum;
  logic signed [W:0] s_dif;

  always_comb begin
    u_sum = {1'b0, op_x} + {1'b0, op_y};
    u_dif = {1'b0, op_x} - {1'b0, op_y};
    s_sum = $signed({op_x[W-1], op_x}) + $signed({op_y[W-1], op_y});
    s_dif = $signed({op_x[W-1], op_x}) - $signed({op_y[W-1], op_y});

    p_add_wrap_r1: assert (sub_sel || result == u_sum[W-1:0])
      else $error("R1 sum wrap mismatch");
    p_sub_wrap_r2: assert (!sub_sel || result == u_dif[W-1:0])
      else $error("R2 difference wrap mismatch");
    p_signed_add_r3: assert (!(signed_mode && !sub_sel) || err == (s_sum[W] != s_sum[W-1]))
      else $error("R3 signed add flag mismatch");
    p_signed_sub_r4: assert (!(signed_mode && sub_sel) || err == (s_dif[W] != s_dif[W-1]))
      else $error("R4 signed subtract flag mismatch");
    p_carry_add_r5: assert (sub_sel || carry_out == u_sum[W])
      else $error("R5 adder carry mismatch");
    p_unsigned_add_r5: assert (!(!signed_mode && !sub_sel) || err == u_sum[W])
      else $error("R5 unsigned add flag mismatch");
    p_unsigned_sub_r6: assert (!(!signed_mode && sub_sel) || err == u_dif[W])
      else $error("R6 borrow flag mismatch");
  end
endmodule

bind addsub_ovf addsub_ovf_chk #(.W(WIDTH)) u_chk (
  .op_x        (op_x),
  .op_y        (op_y),
  .sub_sel     (sub_sel),
  .signed_mode (signed_mode),
  .result      (result),
  .err         (err),
  .carry_out   (carry_out)
);

// File: tb/addsub_ovf_bench.sv
module addsub_ovf_bench;
  localparam int WA = 4;
  localparam int WB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [WA-1:0] xa, ya, za;
  logic          suba, sma, ea;
  logic [WB-1:0] xb, yb, zb;
  logic          subb, smb, eb;

  addsub_ovf #(.WIDTH(WA)) u_addsub_ovf (
    .op_x(xa), .op_y(ya), .sub_sel(suba), .signed_mode(sma), .result(za), .err(ea)
  );
  addsub_ovf #(.WIDTH(WB)) u_addsub_ovf_w6 (
    .op_x(xb), .op_y(yb), .sub_sel(subb), .signed_mode(smb), .result(zb), .err(eb)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // scoreboard queues (one entry per applied vector)
  bit q_wide[$];
  int q_x[$], q_y[$], q_z[$];
  bit q_e[$], q_sub[$], q_sm[$];

  function automatic void ref_calc(input int w, input int x, input int y, input bit sub,
                                   input bit sm, output int z, output bit e);
    int m;
    int sx;
    int sy;
    int ur;
    int sr;
    m  = 1 << w;
    sx = (x >= m / 2) ? x - m : x;
    sy = (y >= m / 2) ? y - m : y;
    ur = sub ? x - y : x + y;
    sr = sub ? sx - sy : sx + sy;
    z  = ((ur % m) + m) % m;
    e  = sm ? (sr < -(m / 2) || sr > m / 2 - 1) : (ur < 0 || ur >= m);
  endfunction

  task automatic drive(input bit wide, input int x, input int y, input bit sub, input bit sm);
    int z;
    bit e;
    @(posedge clk);
    #1;
    if (wide) begin
      xb = WB'(x); yb = WB'(y); subb = sub; smb = sm;
      ref_calc(WB, x, y, sub, sm, z, e);
    end else begin
      xa = WA'(x); ya = WA'(y); suba = sub; sma = sm;
      ref_calc(WA, x, y, sub, sm, z, e);
    end
    q_wide.push_back(wide); q_x.push_back(x); q_y.push_back(y);
    q_z.push_back(z); q_e.push_back(e); q_sub.push_back(sub); q_sm.push_back(sm);
  endtask

  // monitor: compares half a cycle after each vector is applied
  always @(negedge clk) begin
    if (rst_n && q_z.size() > 0) begin
      bit w, s, m, ee;
      int x, y, zz, gz;
      bit ge;
      string rz, re;
      w = q_wide.pop_front(); x = q_x.pop_front(); y = q_y.pop_front();
      zz = q_z.pop_front(); ee = q_e.pop_front();
      s = q_sub.pop_front(); m = q_sm.pop_front();
      gz = w ? int'(zb) : int'(za);
      ge = w ? eb : ea;
      rz = s ? "R2/R7" : "R1/R7";
      re = m ? (s ? "R4" : "R3") : (s ? "R6" : "R5");
      n_checks++;
      if (gz != zz) begin
        n_fails++;
        $display("FAIL %s w=%0d x=%0d y=%0d sub=%0d mode=%0d result=%0d expected=%0d",
                 rz, w ? WB : WA, x, y, s, m, gz, zz);
      end
      n_checks++;
      if (ge != ee) begin
        n_fails++;
        $display("FAIL %s w=%0d x=%0d y=%0d sub=%0d mode=%0d err=%0d expected=%0d",
                 re, w ? WB : WA, x, y, s, m, ge, ee);
      end
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    xa = '0; ya = '0; suba = 1'b0; sma = 1'b0;
    xb = '0; yb = '0; subb = 1'b0; smb = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state with all-zero inputs: R1 zero sum, R5 no carry
    n_checks++;
    if (za != '0 || ea != 1'b0) begin
      n_fails++;
      $display("FAIL R1/R5 idle result=%0d err=%0d expected=0 0", za, ea);
    end
    rst_n = 1'b1;
    for (int sm = 0; sm < 2; sm++)
      for (int sb = 0; sb < 2; sb++)
        for (int x = 0; x < (1 << WA); x++)
          for (int y = 0; y < (1 << WA); y++)
            drive(1'b0, x, y, sb[0], sm[0]);
    for (int sm = 0; sm < 2; sm++)
      for (int sb = 0; sb < 2; sb++)
        for (int x = 0; x < (1 << WB); x++)
          for (int y = 0; y < (1 << WB); y++)
            drive(1'b1, x, y, sb[0], sm[0]);
    while (q_z.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired, queue=%0d expected=0", q_z.size());
      summary();
    end
  end
endmodule